// File: doc/BRIEF.md
# Dual-Pin Phase/Frequency Detector

This block compares the edges of a divided oscillator clock with the edges of a reference clock and reports which one arrived first. Both inputs are brought into the system clock domain through a short synchronizer. A two-flag detector with a shared clear then produces an "up" flag when the divided clock leads and a "down" flag when the reference leads. Each flag stays set for as many system cycles as separate the two edges. Once both flags are set they are held together for a fixed window before they clear. This keeps the pulses from vanishing when the edges nearly coincide.

The result drives two output pins. Each pin is modelled as a data value plus an output enable. In three-level mode both pins carry the same result, so each can feed its own loop filter. A pin drives high while the divided clock leads, drives low while it lags, and is released when there is no difference. In pulse-pair mode the first pin carries the up pulse and the second carries the down pulse, both always driven, for an external charge pump. In three-level mode the second pin can instead be released permanently or used as a plain output port.

Configuration writes are staged. They reach the output encoder only when the detector is idle, so a pulse already in progress finishes in the encoding it started with.

Top module: `phase_det`

## Requirements
- R1: After reset both pins are released (oe low), the block is in three-level mode and the second pin follows the first.
- R2: In three-level mode (`cfg_cp_mode`=0), when the divided clock's rising edge precedes the reference edge by D system cycles, pin 1 drives high (oe=1, out=1) for exactly D cycles and never drives low.
- R3: In three-level mode, when the reference edge precedes the divided edge by D cycles, pin 1 drives low (oe=1, out=0) for exactly D cycles and never drives high.
- R4: In three-level mode, edges that reach the detector in the same cycle leave pin 1 released throughout.
- R5: With second-pin select 0 (follow) in three-level mode, pin 2 matches pin 1's oe and value in every cycle.
- R6: In pulse-pair mode (`cfg_cp_mode`=1) both pins are always driven and idle low. Pin 1 is the up pulse and pin 2 is the down pulse. The leading input's pulse lasts D+RST_DLY cycles and the other pulse lasts RST_DLY cycles. The second-pin select is ignored in this mode.
- R7: The up and down flags are never set together for more than RST_DLY consecutive cycles. In pulse-pair mode, coincident edges give both pulses high for exactly RST_DLY cycles.
- R8: With second-pin select 1 or 3 (release) in three-level mode, pin 2's oe stays low.
- R9: With second-pin select 2 (port) in three-level mode, pin 2 is driven constantly with `cfg_port_val`.
- R10: A configuration written while a pulse is active takes effect only after both flags have cleared. The active configuration never changes while a flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock, asynchronous |
| div_in | input | 1 | Divided oscillator clock, asynchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cp_mode | input | 1 | 0 three-level, 1 pulse-pair |
| cfg_pin2_sel | input | 2 | Second-pin use: 0 follow, 1 release, 2 port, 3 release |
| cfg_port_val | input | 1 | Level for second pin in port use |
| pd1_out | output | 1 | Pin 1 data |
| pd1_oe | output | 1 | Pin 1 output enable |
| pd2_out | output | 1 | Pin 2 data |
| pd2_oe | output | 1 | Pin 2 output enable |

## Verification
The assertions check on every cycle that the registered pin encoding matches the detector flags in each mode. They also check that a released second pin never drives, that the overlap of the two flags never exceeds the clear window, and that the active configuration holds steady while a flag is set. Only the bench scenarios can show that pulse widths equal the edge offset from the input pins, plus the window in pulse-pair mode. The same holds for coincident edges giving no three-level output, and for a write made during a pulse taking effect only after the pulse ends.

// File: rtl/phase_det_pkg.sv
package phase_det_pkg;
  typedef enum logic [1:0] {
    P2_FOLLOW = 2'd0,
    P2_HIZ    = 2'd1,
    P2_PORT   = 2'd2,
    P2_RSVD   = 2'd3
  } pin2_sel_e;

  typedef struct packed {
    logic      cp_mode;
    pin2_sel_e pin2_sel;
    logic      port_val;
  } pd_cfg_t;

  localparam pd_cfg_t CFG_RESET = '{cp_mode: 1'b0, pin2_sel: P2_FOLLOW, port_val: 1'b0};
endpackage

// File: rtl/pd_sync_edge.sv
module pd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/pd_flags.sv
module pd_flags #(
  parameter int RST_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic div_rise,
  input  logic ref_rise,
  output logic up,
  output logic dn
);
  localparam int CW = $clog2(RST_DLY + 1);

  logic [CW-1:0] win_cnt;
  logic          both;
  logic          clr;

  assign both = up & dn;
  assign clr  = both && (win_cnt == CW'(RST_DLY - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      up      <= 1'b0;
      dn      <= 1'b0;
      win_cnt <= '0;
    end else begin
      up      <= (up & ~clr) | div_rise;
      dn      <= (dn & ~clr) | ref_rise;
      win_cnt <= (both && !clr) ? win_cnt + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/pd_cfg_reg.sv
module pd_cfg_reg
  import phase_det_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    we,
  input  pd_cfg_t wdata,
  input  logic    idle,
  output pd_cfg_t act
);
  pd_cfg_t pend;
  logic    pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= CFG_RESET;
      pend_v <= 1'b0;
      act    <= CFG_RESET;
    end else if (we) begin
      pend   <= wdata;
      pend_v <= 1'b1;
    end else if (pend_v && idle) begin
      act    <= pend;
      pend_v <= 1'b0;
    end
  end
endmodule

// File: rtl/pd_encode.sv
module pd_encode
  import phase_det_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    up,
  input  logic    dn,
  input  pd_cfg_t cfg,
  output logic    p1_out,
  output logic    p1_oe,
  output logic    p2_out,
  output logic    p2_oe
);
  logic lead, lag;
  logic n1o, n1e, n2o, n2e;

  assign lead = up & ~dn;
  assign lag  = dn & ~up;

  always_comb begin
    if (cfg.cp_mode) begin
      n1o = up;
      n1e = 1'b1;
      n2o = dn;
      n2e = 1'b1;
    end else begin
      n1o = lead;
      n1e = lead | lag;
      case (cfg.pin2_sel)
        P2_FOLLOW: begin n2o = n1o;          n2e = n1e;  end
        P2_PORT:   begin n2o = cfg.port_val; n2e = 1'b1; end
        default:   begin n2o = 1'b0;         n2e = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_out <= 1'b0;
      p1_oe  <= 1'b0;
      p2_out <= 1'b0;
      p2_oe  <= 1'b0;
    end else begin
      p1_out <= n1o;
      p1_oe  <= n1e;
      p2_out <= n2o;
      p2_oe  <= n2e;
    end
  end
endmodule

// File: rtl/phase_det.sv
module phase_det
  import phase_det_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_DLY     = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_in,
  input  logic       div_in,
  input  logic       cfg_we,
  input  logic       cfg_cp_mode,
  input  logic [1:0] cfg_pin2_sel,
  input  logic       cfg_port_val,
  output logic       pd1_out,
  output logic       pd1_oe,
  output logic       pd2_out,
  output logic       pd2_oe
);
  logic    ref_rise, div_rise;
  logic    flag_up, flag_dn;
  pd_cfg_t cfg_w, cfg_act;
  logic    act_cp;
  logic [1:0] act_sel;

  pd_sync_edge #(.STAGES(SYNC_STAGES)) u_ref_edge (
    .clk(clk), .rst(rst), .d(ref_in), .rise(ref_rise));
  pd_sync_edge #(.STAGES(SYNC_STAGES)) u_div_edge (
    .clk(clk), .rst(rst), .d(div_in), .rise(div_rise));

  pd_flags #(.RST_DLY(RST_DLY)) u_flags (
    .clk(clk), .rst(rst), .div_rise(div_rise), .ref_rise(ref_rise),
    .up(flag_up), .dn(flag_dn));

  assign cfg_w.cp_mode  = cfg_cp_mode;
  assign cfg_w.pin2_sel = pin2_sel_e'(cfg_pin2_sel);
  assign cfg_w.port_val = cfg_port_val;

  pd_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_w),
    .idle(~flag_up & ~flag_dn), .act(cfg_act));

  assign act_cp  = cfg_act.cp_mode;
  assign act_sel = cfg_act.pin2_sel;

  pd_encode u_enc (
    .clk(clk), .rst(rst), .up(flag_up), .dn(flag_dn), .cfg(cfg_act),
    .p1_out(pd1_out), .p1_oe(pd1_oe), .p2_out(pd2_out), .p2_oe(pd2_oe));
endmodule

// File: rtl/phase_det_chk.sv
module phase_det_chk #(
  parameter int RST_DLY = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       up,
  input logic       dn,
  input logic       cp_act,
  input logic [1:0] sel_act,
  input logic       pd1_out,
  input logic       pd1_oe,
  input logic       pd2_out,
  input logic       pd2_oe
);
  logic [15:0] ovl_cnt;

  always_ff @(posedge clk) begin
    if (rst)                             ovl_cnt <= '0;
    else if (up && dn && ovl_cnt != '1)  ovl_cnt <= ovl_cnt + 1'b1;
    else if (!(up && dn))                ovl_cnt <= '0;
  end

  // R2
  a_r2_lead_drives_high: assert property (@(posedge clk) disable iff (rst)
    $past(up && !dn && !cp_act) |-> (pd1_oe && pd1_out));

  // R4
  a_r4_idle_released: assert property (@(posedge clk) disable iff (rst)
    $past(!up && !dn && !cp_act) |-> !pd1_oe);

  // R6
  a_r6_pulse_pair: assert property (@(posedge clk) disable iff (rst)
    $past(cp_act) |-> (pd1_oe && pd2_oe && pd1_out == $past(up) && pd2_out == $past(dn)));

  // R7
  a_r7_overlap_bound: assert property (@(posedge clk) disable iff (rst)
    ovl_cnt <= 16'(RST_DLY));

  // R8
  a_r8_pin2_released: assert property (@(posedge clk) disable iff (rst)
    $past(!cp_act && sel_act[0]) |-> !pd2_oe);

  // R10
  a_r10_cfg_stable_busy: assert property (@(posedge clk) disable iff (rst)
    ((up || dn) && $past(up || dn)) |-> ($stable(cp_act) && $stable(sel_act)));
endmodule

bind phase_det phase_det_chk #(.RST_DLY(RST_DLY)) u_chk (
  .clk(clk), .rst(rst), .up(flag_up), .dn(flag_dn),
  .cp_act(act_cp), .sel_act(act_sel),
  .pd1_out(pd1_out), .pd1_oe(pd1_oe), .pd2_out(pd2_out), .pd2_oe(pd2_oe));

// File: tb/test_phase_det.sv
module test_phase_det;
  localparam int RD = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0, div_in = 1'b0;
  logic cfg_we = 1'b0, cfg_cp_mode = 1'b0, cfg_port_val = 1'b0;
  logic [1:0] cfg_pin2_sel = 2'd0;
  logic pd1_out, pd1_oe, pd2_out, pd2_oe;

  int n_chk = 0, n_fail = 0;
  int hi1, lo1, z1, hi2, lo2, z2, mism, total;
  bit done = 1'b0;

  always #2 clk = ~clk;

  phase_det #(.SYNC_STAGES(2), .RST_DLY(RD)) i_phase_det (
    .clk(clk), .rst(rst), .ref_in(ref_in), .div_in(div_in),
    .cfg_we(cfg_we), .cfg_cp_mode(cfg_cp_mode), .cfg_pin2_sel(cfg_pin2_sel),
    .cfg_port_val(cfg_port_val),
    .pd1_out(pd1_out), .pd1_oe(pd1_oe), .pd2_out(pd2_out), .pd2_oe(pd2_oe));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_p(bit cp, bit divf, int d);
    if (cp) return divf ? d + RD : RD;
    return divf ? d : 0;
  endfunction

  function automatic int exp_n(bit cp, bit divf, int d);
    if (cp) return divf ? RD : d + RD;
    return divf ? 0 : d;
  endfunction

  task automatic set_cfg(input bit cp, input logic [1:0] sel, input bit pv);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cp_mode = cp; cfg_pin2_sel = sel; cfg_port_val = pv;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic sample();
    total++;
    if (pd1_oe &&  pd1_out) hi1++;
    if (pd1_oe && !pd1_out) lo1++;
    if (!pd1_oe) z1++;
    if (pd2_oe &&  pd2_out) hi2++;
    if (pd2_oe && !pd2_out) lo2++;
    if (!pd2_oe) z2++;
    if (pd2_oe != pd1_oe || (pd1_oe && pd2_out != pd1_out)) mism++;
  endtask

  // One edge pair; optional mid-burst write switching to pulse-pair mode.
  task automatic burst(input bit divf, input int d, input bit mid_cfg);
    hi1 = 0; lo1 = 0; z1 = 0; hi2 = 0; lo2 = 0; z2 = 0; mism = 0; total = 0;
    for (int i = 0; i < d + RD + 12; i++) begin
      @(negedge clk);
      sample();
      if (i == 0) begin
        if (divf || d == 0) div_in = 1'b1;
        if (!divf || d == 0) ref_in = 1'b1;
      end
      if (i == d && d != 0) begin
        if (divf) ref_in = 1'b1; else div_in = 1'b1;
      end
      if (mid_cfg && i == 5) begin
        cfg_we = 1'b1; cfg_cp_mode = 1'b1; cfg_pin2_sel = 2'd0;
      end
      if (mid_cfg && i == 6) cfg_we = 1'b0;
    end
    @(negedge clk);
    div_in = 1'b0; ref_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_burst(input bit cp, input logic [1:0] sel, input bit pv,
                             input bit divf, input int d);
    if (cp) begin
      chk("R6 P width", hi1, exp_p(1, divf, d));
      chk("R6 N width", hi2, exp_n(1, divf, d));
      chk("R6 pins driven", z1 + z2, 0);
      if (d == 0) chk("R7 coincident overlap", hi1 + hi2, 2 * RD);
    end else begin
      chk(divf ? "R2 high width" : "R3 low width", divf ? hi1 : lo1, divf ? d : d);
      chk(divf ? "R2 no low" : "R3 no high", divf ? lo1 : hi1, 0);
      if (d == 0) chk("R4 coincident released", total - z1, 0);
      case (sel)
        2'd0: chk("R5 follow mismatch", mism, 0);
        2'd2: chk("R9 port level", pv ? hi2 : lo2, total);
        default: chk("R8 pin2 released", z2, total);
      endcase
    end
  endtask

  initial begin
    void'($urandom(32'd7301));
    repeat (4) @(negedge clk);
    chk("R1 pin1 oe in reset", int'(pd1_oe), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pin1 oe after reset", int'(pd1_oe), 0);
    chk("R1 pin2 oe after reset", int'(pd2_oe), 0);

    // Directed: default config (three-level, follow)
    burst(1, 5, 0);  check_burst(0, 2'd0, 0, 1, 5);
    burst(0, 7, 0);  check_burst(0, 2'd0, 0, 0, 7);
    burst(1, 0, 0);  check_burst(0, 2'd0, 0, 1, 0);
    burst(1, 1, 0);  check_burst(0, 2'd0, 0, 1, 1);

    set_cfg(0, 2'd1, 0); burst(1, 4, 0); check_burst(0, 2'd1, 0, 1, 4);
    set_cfg(0, 2'd3, 0); burst(0, 3, 0); check_burst(0, 2'd3, 0, 0, 3);
    set_cfg(0, 2'd2, 1); burst(0, 6, 0); check_burst(0, 2'd2, 1, 0, 6);

    set_cfg(1, 2'd1, 0); burst(1, 6, 0); check_burst(1, 2'd1, 0, 1, 6);
    burst(0, 4, 0); check_burst(1, 2'd1, 0, 0, 4);
    burst(1, 0, 0); check_burst(1, 2'd1, 0, 1, 0);

    // R10: write to pulse-pair mode during a three-level burst
    set_cfg(0, 2'd0, 0);
    burst(1, 8, 1);
    chk("R10 burst keeps old encoding", hi1, 8);
    chk("R10 new mode applied after idle pin1 oe", int'(pd1_oe), 1);
    chk("R10 new mode applied after idle pin1 out", int'(pd1_out), 0);

    // Random mix
    for (int k = 0; k < 24; k++) begin
      bit cp, divf, pv;
      logic [1:0] sel;
      int d;
      cp = 1'($urandom_range(0, 1));
      sel = 2'($urandom_range(0, 3));
      pv = 1'($urandom_range(0, 1));
      divf = 1'($urandom_range(0, 1));
      d = int'($urandom_range(0, 12));
      set_cfg(cp, sel, pv);
      burst(divf, d, 0);
      check_burst(cp, sel, pv, divf, d);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule